// File: doc/BRIEF.md
# Paged Address Relocation Unit

This block turns a 15-bit program address plus a 3-bit state number into an 18-bit physical word address. The mapping comes from a table of 128 page indexes. Each index describes one 2048-word physical page: its page number, the quarter of that page where the program's space starts, how many quarters the program may use, and whether the page may be written. The table is stored as 64 words, each holding two indexes. Every state number owns 16 indexes, and the top four bits of the program address select one of them. The translation is purely combinational from the stored table, so the physical address, the storage bus choice and the protection verdict appear in the same cycle as the request.

The table is loaded and inspected through a plain numbered port. A load is sampled on the clock edge and affects translations from the next cycle on. The readback port is combinational. Both the request side and the load side are plain control pins with no valid/ready handshake. A request is taken whenever `req_valid_i` is high, and the block never applies back-pressure. On an illegal access the block raises an interrupt line and holds back the memory write strobe.

Index number convention: index number = {state[2:0], program address bits 14..11}. The number's bit 0 picks the low (even) or high (odd) half of a 24-bit table word. Index field layout: bit 11 = exclusion flag X, bits 10..9 = length LEN, bits 8..2 = page number PG, bits 1..0 = start quarter SQ.

Top module: `paged_reloc_unit`

## Requirements
- R1: A load with `idx_wr_en_i` high stores `idx_wr_data_i` at index number `idx_wr_num_i` on the clock edge. `idx_rd_data_o` shows the stored 12 bits of index `idx_rd_num_i` combinationally. Reset clears every index to zero.
- R2: A translation uses the index numbered {req_state_i, req_addr_i[14:11]}. The two indexes that share one table word (numbers differing only in bit 0) are stored and used independently.
- R3: For index numbers other than zero, phys_addr_o[17:11] equals PG (bits 8..2 of the index) and phys_addr_o[8:0] equals req_addr_i[8:0].
- R4: phys_addr_o[10:9] equals (SQ + req_addr_i[10:9]) modulo 4.
- R5: bus_left_o equals phys_addr_o[17]. A value of 1 selects the left storage bus and 0 selects the right one.
- R6: When LEN is nonzero, LEN is the number of quarters allowed. A valid request with req_addr_i[10:9] >= LEN raises illegal_wr_o, whether it reads or writes. LEN = 0 allows all four quarters.
- R7: When X = 1 and the other 11 bits are not all zero, the page is read-only. A valid write raises illegal_wr_o, and a valid read does not.
- R8: An index equal to 12'h800 (X = 1, all else zero) marks an unaddressable page. Any valid request through it raises illegal_wr_o.
- R9: For index number zero, PG and SQ are treated as zero during translation. Readback still returns the stored value.
- R10: mem_wr_o is high exactly when req_valid_i and req_write_i are high and illegal_wr_o is low. With req_valid_i low, both illegal_wr_o and mem_wr_o stay low.
- R11: Translation outputs follow the request inputs in the same cycle. A load changes the translation only after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_state_i | input | 3 | State number of the request |
| req_addr_i | input | 15 | Program address |
| req_write_i | input | 1 | Request is a write |
| phys_addr_o | output | 18 | Relocated physical word address |
| bus_left_o | output | 1 | Storage bus select (1 = left) |
| illegal_wr_o | output | 1 | Illegal-write interrupt |
| mem_wr_o | output | 1 | Memory write strobe, held back on a violation |
| idx_wr_en_i | input | 1 | Load an index on this edge |
| idx_wr_num_i | input | 7 | Index number to load |
| idx_wr_data_i | input | 12 | Index value to load |
| idx_rd_num_i | input | 7 | Index number to read back |
| idx_rd_data_o | output | 12 | Stored value of the index being read back |

## Verification
The assertions assume that request and load inputs are known and settle between clock edges. The bench drives every input on the falling edge and samples outputs one nanosecond later, well before the next rising edge. The load assertion also assumes that reset does not fall in the cycle right after a load; the bench asserts reset only once, at the start. The directed scenarios cover both halves of one table word, every length code, a start quarter that wraps past the fourth quarter, the read-only and unaddressable encodings, and index number zero against its odd neighbour.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int QTR_W  = 2;
  localparam int PG_W   = 7;
  localparam int IDX_W  = 1 + QTR_W + PG_W + QTR_W;

  typedef struct packed {
    logic             excl;
    logic [QTR_W-1:0] len;
    logic [PG_W-1:0]  pg;
    logic [QTR_W-1:0] sq;
  } pidx_t;
endpackage

// File: rtl/reloc_index_file.sv
module reloc_index_file #(
  parameter int NUM_W = 7,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [NUM_W-1:0] wr_num_i,
  input  logic [IDX_W-1:0] wr_data_i,
  input  logic [NUM_W-1:0] rd_num_i,
  output logic [IDX_W-1:0] rd_data_o,
  input  logic [NUM_W-1:0] lk_num_i,
  output logic [IDX_W-1:0] lk_data_o
);
  localparam int LOC_W = NUM_W - 1;
  localparam int DEPTH = 1 << LOC_W;

  logic [IDX_W-1:0] rd_half [2];
  logic [IDX_W-1:0] lk_half [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [IDX_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en_i && (wr_num_i[0] == 1'(h))) begin
        mem_q[wr_num_i[NUM_W-1:1]] <= wr_data_i;
      end
    end

    assign rd_half[h] = mem_q[rd_num_i[NUM_W-1:1]];
    assign lk_half[h] = mem_q[lk_num_i[NUM_W-1:1]];

    // R1
    load_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (wr_num_i[0] == 1'(h)))
        |=> mem_q[$past(wr_num_i[NUM_W-1:1])] == $past(wr_data_i));
  end

  assign rd_data_o = rd_half[rd_num_i[0]];
  assign lk_data_o = lk_half[lk_num_i[0]];
endmodule

// File: rtl/reloc_quarter_adder.sv
module reloc_quarter_adder #(
  parameter int QW = 2
) (
  input  logic [QW-1:0] start_i,
  input  logic [QW-1:0] rel_i,
  output logic [QW-1:0] phys_o
);
  assign phys_o = start_i + rel_i;
endmodule

// File: rtl/reloc_protect.sv
module reloc_protect
  import reloc_pkg::*;
(
  input  logic             valid_i,
  input  logic             write_i,
  input  pidx_t            entry_i,
  input  logic [QTR_W-1:0] rel_q_i,
  output logic             illegal_o,
  output logic             strobe_o
);
  logic unaddr, rdonly, over_len;

  always_comb begin
    unaddr   = entry_i.excl && (entry_i.len == '0) && (entry_i.pg == '0) && (entry_i.sq == '0);
    rdonly   = entry_i.excl && !unaddr;
    over_len = (entry_i.len != '0) && (rel_q_i >= entry_i.len);
    illegal_o = valid_i && (unaddr || over_len || (rdonly && write_i));
    strobe_o  = valid_i && write_i && !illegal_o;
  end
endmodule

// File: rtl/paged_reloc_unit.sv
module paged_reloc_unit
  import reloc_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int ADDR_W  = 15,
  parameter int OFF_W   = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  input  logic [STATE_W-1:0]        req_state_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic                      req_write_i,
  output logic [PG_W+QTR_W+OFF_W-1:0] phys_addr_o,
  output logic                      bus_left_o,
  output logic                      illegal_wr_o,
  output logic                      mem_wr_o,
  input  logic                      idx_wr_en_i,
  input  logic [STATE_W+ADDR_W-OFF_W-QTR_W-1:0] idx_wr_num_i,
  input  logic [IDX_W-1:0]          idx_wr_data_i,
  input  logic [STATE_W+ADDR_W-OFF_W-QTR_W-1:0] idx_rd_num_i,
  output logic [IDX_W-1:0]          idx_rd_data_o
);
  localparam int SEL_W  = ADDR_W - OFF_W - QTR_W;
  localparam int NUM_W  = STATE_W + SEL_W;
  localparam int PHYS_W = PG_W + QTR_W + OFF_W;

  logic [NUM_W-1:0] lk_num;
  logic [IDX_W-1:0] lk_raw;
  pidx_t            entry;
  logic             is_zero;
  logic [PG_W-1:0]  pg_eff;
  logic [QTR_W-1:0] sq_eff, rel_q, phys_q;

  assign lk_num = {req_state_i, req_addr_i[ADDR_W-1 -: SEL_W]};
  assign rel_q  = req_addr_i[OFF_W +: QTR_W];

  reloc_index_file #(.NUM_W(NUM_W), .IDX_W(IDX_W)) u_file (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (idx_wr_en_i),
    .wr_num_i  (idx_wr_num_i),
    .wr_data_i (idx_wr_data_i),
    .rd_num_i  (idx_rd_num_i),
    .rd_data_o (idx_rd_data_o),
    .lk_num_i  (lk_num),
    .lk_data_o (lk_raw)
  );

  assign entry   = pidx_t'(lk_raw);
  assign is_zero = (lk_num == '0);
  assign pg_eff  = is_zero ? '0 : entry.pg;
  assign sq_eff  = is_zero ? '0 : entry.sq;

  reloc_quarter_adder #(.QW(QTR_W)) u_qadd (
    .start_i (sq_eff),
    .rel_i   (rel_q),
    .phys_o  (phys_q)
  );

  reloc_protect u_prot (
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .entry_i   (entry),
    .rel_q_i   (rel_q),
    .illegal_o (illegal_wr_o),
    .strobe_o  (mem_wr_o)
  );

  assign phys_addr_o = {pg_eff, phys_q, req_addr_i[OFF_W-1:0]};
  assign bus_left_o  = phys_addr_o[PHYS_W-1];

  // R9
  zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && lk_num == '0)
      |-> (phys_addr_o[PHYS_W-1 -: PG_W] == '0) && (phys_addr_o[OFF_W +: QTR_W] == rel_q));

  // R8
  unaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && lk_raw == {1'b1, {(IDX_W-1){1'b0}}}) |-> illegal_wr_o);

  // R7
  rdonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && lk_raw[IDX_W-1] && lk_raw[IDX_W-2:0] != '0)
      |-> (illegal_wr_o && !mem_wr_o));

  // R6
  length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && entry.len != '0 && rel_q >= entry.len) |-> illegal_wr_o);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |-> (!illegal_wr_o && !mem_wr_o));
endmodule

// File: tb/sim_paged_reloc_unit.sv
module sim_paged_reloc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_state_i = '0;
  logic [14:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic [17:0] phys_addr_o;
  logic        bus_left_o, illegal_wr_o, mem_wr_o;
  logic        idx_wr_en_i = 1'b0;
  logic [6:0]  idx_wr_num_i = '0;
  logic [11:0] idx_wr_data_i = '0;
  logic [6:0]  idx_rd_num_i = '0;
  logic [11:0] idx_rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  paged_reloc_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [6:0] num, input logic [11:0] data);
    @(negedge clk);
    idx_wr_en_i = 1'b1; idx_wr_num_i = num; idx_wr_data_i = data;
    @(negedge clk);
    idx_wr_en_i = 1'b0;
  endtask

  task automatic req(input logic [2:0] st, input logic [14:0] a, input logic wr);
    @(negedge clk);
    req_valid_i = 1'b1; req_state_i = st; req_addr_i = a; req_write_i = wr;
    #1;
  endtask

  task automatic t_reset;
    idx_rd_num_i = 7'd5;   #1; chk("R1 reset clear idx5", idx_rd_data_o, 0);
    idx_rd_num_i = 7'd127; #1; chk("R1 reset clear idx127", idx_rd_data_o, 0);
    chk("R10 idle illegal", illegal_wr_o, 0);
    chk("R10 idle strobe", mem_wr_o, 0);
  endtask

  task automatic t_translate;
    load(7'd43, 12'h155);
    load(7'd42, 12'h00F);
    idx_rd_num_i = 7'd43; #1; chk("R1 readback 43", idx_rd_data_o, 12'h155);
    idx_rd_num_i = 7'd42; #1; chk("R2 readback even half 42", idx_rd_data_o, 12'h00F);
    req(3'd2, 15'h5CA5, 1'b0);
    chk("R3 R4 phys odd half", phys_addr_o, 18'h2AEA5);
    chk("R5 bus left", bus_left_o, 1);
    chk("R6 full page no fault", illegal_wr_o, 0);
    req(3'd2, 15'h57FF, 1'b0);
    chk("R2 R4 phys even half wrap", phys_addr_o, 18'h01DFF);
    chk("R5 bus right", bus_left_o, 0);
  endtask

  task automatic t_length;
    load(7'd10, 12'h500);
    req(3'd0, 15'h5234, 1'b0);
    chk("R6 half page q1 legal", illegal_wr_o, 0);
    chk("R3 phys len page", phys_addr_o, 18'h20234);
    req(3'd0, 15'h5434, 1'b0);
    chk("R6 half page q2 read fault", illegal_wr_o, 1);
    req(3'd0, 15'h5634, 1'b1);
    chk("R6 half page q3 write fault", illegal_wr_o, 1);
    chk("R10 no strobe on fault", mem_wr_o, 0);
    load(7'd11, 12'h200);
    req(3'd0, 15'h5800, 1'b0);
    chk("R6 quarter page q0 legal", illegal_wr_o, 0);
    req(3'd0, 15'h5A00, 1'b0);
    chk("R6 quarter page q1 fault", illegal_wr_o, 1);
    load(7'd12, 12'h600);
    req(3'd0, 15'h6400, 1'b0);
    chk("R6 three quarter q2 legal", illegal_wr_o, 0);
    req(3'd0, 15'h6600, 1'b0);
    chk("R6 three quarter q3 fault", illegal_wr_o, 1);
  endtask

  task automatic t_readonly;
    load(7'd20, 12'h846);
    req(3'd1, 15'h2010, 1'b0);
    chk("R7 read-only read ok", illegal_wr_o, 0);
    chk("R4 read-only phys", phys_addr_o, 18'h08C10);
    req(3'd1, 15'h2010, 1'b1);
    chk("R7 read-only write fault", illegal_wr_o, 1);
    chk("R7 read-only strobe held", mem_wr_o, 0);
  endtask

  task automatic t_unaddr;
    load(7'd30, 12'h800);
    req(3'd1, 15'h7000, 1'b0);
    chk("R8 unaddressable read", illegal_wr_o, 1);
    req(3'd1, 15'h7000, 1'b1);
    chk("R8 unaddressable write", illegal_wr_o, 1);
    @(negedge clk); req_valid_i = 1'b0; #1;
    chk("R10 invalid no interrupt", illegal_wr_o, 0);
    chk("R10 invalid no strobe", mem_wr_o, 0);
  endtask

  task automatic t_strobe;
    req(3'd2, 15'h5CA5, 1'b1);
    chk("R10 legal write strobe", mem_wr_o, 1);
    chk("R10 legal write no fault", illegal_wr_o, 0);
  endtask

  task automatic t_zero;
    load(7'd0, 12'h1FF);
    load(7'd1, 12'h1FF);
    idx_rd_num_i = 7'd0; #1; chk("R9 stored value kept", idx_rd_data_o, 12'h1FF);
    req(3'd0, 15'h0412, 1'b0);
    chk("R9 page zero forced", phys_addr_o, 18'h00412);
    chk("R5 page zero right bus", bus_left_o, 0);
    req(3'd0, 15'h0C12, 1'b0);
    chk("R9 neighbour not forced", phys_addr_o, 18'h3FA12);
  endtask

  task automatic t_timing;
    req(3'd2, 15'h5CA5, 1'b0);
    idx_wr_en_i = 1'b1; idx_wr_num_i = 7'd43; idx_wr_data_i = 12'h0A0;
    #1; chk("R11 old mapping before edge", phys_addr_o, 18'h2AEA5);
    @(negedge clk); idx_wr_en_i = 1'b0; #1;
    chk("R11 new mapping after edge", phys_addr_o, 18'h144A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_translate();
    t_length();
    t_readonly();
    t_unaddr();
    t_strobe();
    t_zero();
    t_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule